// File: doc/BRIEF.md
# Triggered Capture Buffer Controller

This block is the acquisition front end of a sampling scope's memory. A stream of signed samples arrives with a valid strobe. The controller decimates the stream by a programmable ratio and drives the write port of an external on-chip RAM. Writes go to consecutive addresses from zero.

Capture ends in one of two ways. A trigger, which is a rising or falling crossing of a programmable signed level, ends it, and so does filling the last RAM location. In both cases the controller stays stopped until a restart pulse. A hold input pauses acquisition only while it is high. Status outputs report the trigger, the full condition and the address of the most recent write. Readout of the RAM belongs to other logic.

Top module: `trigcap_ctrl`

## Requirements
- R1: While reset is active and after it is released, `ram_we`, `triggered` and `full` are 0 and `last_addr` is 0.
- R2: A sample is accepted when `smp_valid` is 1, `hold` is 0, `restart` is 0 and capture is not stopped. With N = max(`rate_div`, 1), the k-th accepted sample since reset or restart (k from 0) is written exactly when k mod N = 0. A write shows on `ram_we`, `ram_addr` and `ram_wdata` in the cycle after the sample.
- R3: Write addresses run 0, 1, 2, ... in order. `last_addr` holds the address of the latest write.
- R4: The write to address 2^ADDR_W-1 sets `full` together with that write and wraps the address counter to 0. No further writes occur until restart.
- R5: With `arm`=1 and `fall_sel`=0, an accepted sample at or above `trig_level` sets `triggered` in the next cycle if the previous accepted sample was below the level. Comparisons are signed. The triggering sample is still written if it falls on a divider slot. No later sample is written.
- R6: With `arm`=1 and `fall_sel`=1, the trigger fires when the previous accepted sample is at or above the level and the current one is below it. It then behaves as in R5.
- R7: With `arm`=0, crossings have no effect and `triggered` stays 0.
- R8: While `hold` is 1, nothing is written. The divider phase and the remembered previous sample do not move. Capture resumes where it left off when `hold` falls.
- R9: A `restart` pulse clears `triggered`, `full`, the address counter, the divider phase and the previous-sample memory. A sample that arrives in the restart cycle is dropped.
- R10: The first accepted sample after reset or restart cannot fire the trigger.
- R11: Cycles with `smp_valid`=0 write nothing and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed sample |
| rate_div | input | DIV_W | Decimation ratio (0 and 1 both mean every sample) |
| trig_level | input | DATA_W | Signed trigger threshold |
| fall_sel | input | 1 | 0 = rising crossing, 1 = falling crossing |
| arm | input | 1 | Enables the trigger |
| hold | input | 1 | Pauses acquisition while high |
| restart | input | 1 | Pulse that clears status and restarts capture |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| triggered | output | 1 | Trigger has fired |
| full | output | 1 | Last RAM location has been written |
| last_addr | output | ADDR_W | Address of the most recent write |

## Verification
On every cycle the assertions check these rules:
- no write follows a cycle in which the block was full, triggered, holding or idle;
- `full` rises only together with a write to the top address;
- a restart always clears both flags;
- the trigger never fires while disarmed.

Some behaviour only the bench scenarios can show. These are the decimation phase across ratios, the exact order of addresses, and signed crossing detection against several levels in both polarities. They also include the resumption of phase after hold and the rule that the first sample after restart cannot trigger. The bench checks all of these against a model built from the requirements.

// File: rtl/trigcap_pkg.sv
package trigcap_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/trigcap_rate_gate.sv
module trigcap_rate_gate #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [DIV_W-1:0] div,
  output logic             slot
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [CW-1:0]    div_eff;
  logic [CW-1:0]    cnt_inc;

  always_comb begin
    div_eff = (div <= DIV_W'(1)) ? CW'(1) : {1'b0, div};
    cnt_inc = {1'b0, cnt_q} + CW'(1);
    cnt_d   = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = (cnt_inc >= div_eff) ? '0 : cnt_inc[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || adv) begin
      cnt_q <= cnt_d;
    end
  end

  assign slot = (cnt_q == '0);
endmodule

// File: rtl/trigcap_cross_det.sv
module trigcap_cross_det
  import trigcap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              en,
  input  edge_sel_e         edge_sel,
  input  logic [DATA_W-1:0] smp,
  input  logic [DATA_W-1:0] level,
  output logic              hit
);
  logic [DATA_W-1:0] prev_q, prev_d;
  logic              seen_q, seen_d;
  logic              prev_below, cur_below;

  always_comb begin
    prev_below = $signed(prev_q) < $signed(level);
    cur_below  = $signed(smp) < $signed(level);
    hit = 1'b0;
    if (en && seen_q) begin
      if (edge_sel == EDGE_RISE) hit = prev_below && !cur_below;
      else                       hit = !prev_below && cur_below;
    end
    prev_d = prev_q;
    seen_d = seen_q;
    if (clr) begin
      seen_d = 1'b0;
    end else if (adv) begin
      prev_d = smp;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (clr || adv) begin
      prev_q <= prev_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/trigcap_wr_ptr.sv
module trigcap_wr_ptr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr,
  output logic              wrap
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    wrap  = inc && (ptr_q == TOP);
    ptr_d = ptr_q;
    if (clr)       ptr_d = '0;
    else if (wrap) ptr_d = '0;
    else if (inc)  ptr_d = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr || inc) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/trigcap_ctrl.sv
module trigcap_ctrl
  import trigcap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DIV_W-1:0]  rate_div,
  input  logic [DATA_W-1:0] trig_level,
  input  logic              fall_sel,
  input  logic              arm,
  input  logic              hold,
  input  logic              restart,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              triggered,
  output logic              full,
  output logic [ADDR_W-1:0] last_addr
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic              stopped, accept, slot, hit, do_wr, wrap;
  logic [ADDR_W-1:0] wr_ptr;
  edge_sel_e         edge_sel;

  logic              trig_q, trig_d;
  logic              full_q, full_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [ADDR_W-1:0] last_q, last_d;

  assign edge_sel = fall_sel ? EDGE_FALL : EDGE_RISE;
  assign stopped  = trig_q || full_q;
  assign accept   = smp_valid && !hold && !restart && !stopped;
  assign do_wr    = accept && slot;

  trigcap_rate_gate #(.DIV_W(DIV_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (restart),
    .adv   (accept),
    .div   (rate_div),
    .slot  (slot)
  );

  trigcap_cross_det #(.DATA_W(DATA_W)) u_cross (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (restart),
    .adv      (accept),
    .en       (arm),
    .edge_sel (edge_sel),
    .smp      (smp_data),
    .level    (trig_level),
    .hit      (hit)
  );

  trigcap_wr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (restart),
    .inc   (do_wr),
    .ptr   (wr_ptr),
    .wrap  (wrap)
  );

  always_comb begin
    we_d   = do_wr;
    addr_d = do_wr ? wr_ptr : addr_q;
    data_d = do_wr ? smp_data : data_q;
    last_d = do_wr ? wr_ptr : last_q;
    trig_d = trig_q;
    full_d = full_q;
    if (restart) begin
      trig_d = 1'b0;
      full_d = 1'b0;
    end else begin
      if (accept && hit) trig_d = 1'b1;
      if (wrap)          full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      we_q   <= 1'b0;
      trig_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      we_q   <= we_d;
      trig_q <= trig_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_q <= '0;
      data_q <= '0;
      last_q <= '0;
    end else if (do_wr) begin
      addr_q <= addr_d;
      data_q <= data_d;
      last_q <= last_d;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;
  assign triggered = trig_q;
  assign full      = full_q;
  assign last_addr = last_q;
endmodule

// File: rtl/trigcap_chk.sv
module trigcap_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              arm,
  input logic              hold,
  input logic              restart,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              triggered,
  input logic              full
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  // R4
  full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !ram_we);

  // R4
  full_rises_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (ram_we && ram_addr == TOP));

  // R5
  trig_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    triggered |=> !ram_we);

  // R7
  disarmed_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !triggered) |=> !triggered);

  // R8
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !ram_we);

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!triggered && !full && !ram_we));

  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !ram_we);
endmodule

bind trigcap_ctrl trigcap_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .DIV_W  (DIV_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .arm       (arm),
  .hold      (hold),
  .restart   (restart),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .triggered (triggered),
  .full      (full)
);

// File: tb/trigcap_ctrl_tb.sv
`timescale 1ns/1ps
module trigcap_ctrl_tb;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int VW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid, fall_sel, arm, hold, restart;
  logic [DW-1:0] smp_data, trig_level;
  logic [VW-1:0] rate_div;
  logic          ram_we, triggered, full;
  logic [AW-1:0] ram_addr, last_addr;
  logic [DW-1:0] ram_wdata;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  int m_cnt, m_addr, m_last;
  int m_prev;
  bit m_seen, m_trig, m_full;
  bit e_we;
  int e_addr, e_data;

  always #2.5 clk = ~clk;

  trigcap_ctrl #(.DATA_W(DW), .ADDR_W(AW), .DIV_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rate_div(rate_div), .trig_level(trig_level), .fall_sel(fall_sel),
    .arm(arm), .hold(hold), .restart(restart), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .triggered(triggered),
    .full(full), .last_addr(last_addr)
  );

  task automatic model_clear();
    m_cnt = 0; m_addr = 0; m_seen = 0; m_trig = 0; m_full = 0;
  endtask

  task automatic compare(input string req);
    bit ok;
    ok = (ram_we == e_we) && (triggered == m_trig) && (full == m_full) &&
         (int'(last_addr) == m_last);
    if (e_we) ok = ok && (int'(ram_addr) == e_addr) &&
                   ($signed(ram_wdata) == DW'(e_data));
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got we=%0b addr=%0d data=%0d trig=%0b full=%0b last=%0d exp we=%0b addr=%0d data=%0d trig=%0b full=%0b last=%0d",
               req, ram_we, ram_addr, $signed(ram_wdata), triggered, full, last_addr,
               e_we, e_addr, e_data, m_trig, m_full, m_last);
    end
  endtask

  // one cycle: drive at negedge, predict, check at next negedge
  task automatic cyc(input bit v, input int d, input bit h, input bit rs, input string req);
    int n;
    smp_valid = v; smp_data = DW'(d); hold = h; restart = rs;
    e_we = 0;
    if (rs) begin
      model_clear();
    end else if (v && !h && !m_trig && !m_full) begin
      n = (rate_div <= 1) ? 1 : int'(rate_div);
      if (m_cnt == 0) begin
        e_we = 1; e_addr = m_addr; e_data = d; m_last = m_addr;
        if (m_addr == DEPTH - 1) begin m_full = 1; m_addr = 0; end
        else m_addr++;
      end
      m_cnt = (m_cnt + 1 >= n) ? 0 : m_cnt + 1;
      if (arm && m_seen) begin
        if (!fall_sel && m_prev < $signed(trig_level) && d >= $signed(trig_level)) m_trig = 1;
        if (fall_sel && m_prev >= $signed(trig_level) && d < $signed(trig_level)) m_trig = 1;
      end
      m_prev = d; m_seen = 1;
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  initial begin : watchdog
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; smp_valid = 0; smp_data = '0; hold = 0; restart = 0;
    arm = 0; fall_sel = 0; rate_div = '0; trig_level = '0;
    model_clear(); m_last = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    e_we = 0;
    compare("R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare("R1");

    // R2 R3 R4: divider sweep, fill to wrap, free-running (arm low)
    for (int dv = 0; dv <= 5; dv++) begin
      rate_div = VW'(dv);
      cyc(0, 0, 0, 1, "R9");
      for (int k = 0; k < DEPTH * 6 + 3; k++) begin
        cyc(1, k * 37 - 500, 0, 0, "R2");
        if (k % 5 == 2) cyc(0, 999, 0, 0, "R11");
      end
      cyc(1, 1, 0, 0, "R4");
    end

    // R5 R6 R10: crossings over signed ramps and levels, both polarities
    rate_div = VW'(1);
    arm = 1;
    for (int pol = 0; pol < 2; pol++) begin
      fall_sel = pol[0];
      for (int lv = -3; lv <= 3; lv += 3) begin
        trig_level = DW'(lv);
        for (int st = -5; st <= 5; st++) begin
          cyc(0, 0, 0, 1, "R9");
          for (int k = 0; k < 7; k++)
            cyc(1, pol ? st - k : st + k, 0, 0, pol ? "R6" : "R5");
        end
      end
    end

    // R10: first sample already past level, no prior sample
    fall_sel = 0; trig_level = DW'(0);
    cyc(0, 0, 0, 1, "R9");
    cyc(1, 5, 0, 0, "R10");
    cyc(1, 6, 0, 0, "R10");

    // R7: disarmed crossings ignored
    arm = 0;
    cyc(0, 0, 0, 1, "R9");
    for (int k = 0; k < 6; k++) cyc(1, (k % 2) ? 10 : -10, 0, 0, "R7");

    // R8: hold freezes divider phase and previous sample
    arm = 1; rate_div = VW'(3); trig_level = DW'(0);
    cyc(0, 0, 0, 1, "R9");
    cyc(1, -4, 0, 0, "R8");
    cyc(1, -3, 0, 0, "R8");
    for (int k = 0; k < 4; k++) cyc(1, 50, 1, 0, "R8");
    cyc(1, -2, 0, 0, "R8");
    cyc(1, -1, 0, 0, "R8");
    cyc(1, 7, 0, 0, "R5");
    cyc(1, 8, 0, 0, "R5");

    // R9: restart with a sample in the same cycle drops it
    rate_div = VW'(1);
    cyc(1, 42, 0, 1, "R9");
    cyc(1, 43, 0, 0, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule